// File: doc/BRIEF.md
# Shared Physical Register Reference Tracker

This block counts sharers of physical registers when two or more architectural names, or a register and a bypassed load, point at the same physical register. A small fully associative table holds one entry per shared register. The entry key is the physical register number. Each entry has two up-counters: `ref` counts extra references taken at rename, and `com` counts overwritten mappings that have committed. Neither counter is ever decremented. A counter only returns to zero when its entry is released.

The rename stage uses the reference port for each eliminated move or bypassed load. The port grants or refuses the sharing in the same cycle. When the commit stage retires an instruction, it uses the reclaim port for the physical register of the old mapping. The port reports in the same cycle whether that register can go back to the free list. Only the `ref` field is stored in a checkpoint, so a flush restores the table in one cycle. Registers released by a restore are sent out afterwards, one per cycle, on a separate recovery output.

Top module: `shared_reg_tracker`

## Requirements
- R1: A reference to an untracked register takes the lowest-index entry that is neither valid nor waiting for recovery release, and is accepted. The new entry starts with ref=1 and com=0, so it needs two reclaims before it is freed.
- R2: A reference to an untracked register is refused (refAccept=0) when no entry is available.
- R3: A reference to a tracked register increments its ref and is accepted, even when the table is full. It is refused when ref is already at its maximum (all ones).
- R4: A reclaim that hits an entry whose ref differs from com increments com and reports relFree=0.
- R5: A reclaim that hits an entry whose ref equals com reports relFree=1 and releases the entry.
- R6: A reclaim whose register is not tracked reports relFree=1.
- R7: A save stores the ref of every entry into the chosen checkpoint, as the values stand at the start of that cycle. A restore loads ref from the chosen checkpoint. If the live com is greater than the restored ref, the entry is released and its register appears on recFreeValid/recFreePreg starting in the next cycle. Such registers are released one per cycle, lowest entry first. Otherwise the restored ref is kept.
- R8: On restore, an entry whose restored ref and com are both zero is released without any register being released.
- R9: When an entry is released, its ref is cleared in every checkpoint.
- R10: In a restore cycle the reference and reclaim ports are ignored, and refAccept and relFree are both 0.
- R11: A reclaim in the same cycle as an allocation of the same register sees the table as it was before the allocation. A reference to an entry that a reclaim in the same cycle releases is refused.
- R12: After reset no register is tracked and recFreeValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refValid | input | 1 | Reference request from rename |
| refPreg | input | PREG_W | Physical register being shared |
| refAccept | output | 1 | Sharing granted this cycle |
| relValid | input | 1 | Reclaim lookup from commit |
| relPreg | input | PREG_W | Physical register of the overwritten mapping |
| relFree | output | 1 | relPreg may return to the free list |
| ckSave | input | 1 | Save ref fields into a checkpoint |
| ckSaveId | input | CKPT_W | Checkpoint to save into |
| ckRestore | input | 1 | Restore from a checkpoint |
| ckRestoreId | input | CKPT_W | Checkpoint to restore from |
| recFreeValid | output | 1 | A register released by recovery is presented |
| recFreePreg | output | PREG_W | That register |

## Verification
The hardest case to reach from the ports is a restore that must tell three kinds of entry apart. Some entries lose their register, some vanish without releasing anything, and some keep a restored count. The stimulus builds each case deliberately. It saves a checkpoint, then adds references and reclaims afterwards so that com rises above the saved ref. It also allocates a second register after the save, so that its checkpoint value is zero. A further sequence frees an entry after a save and then reuses it. A restore then shows whether the stale checkpoint value was cleared.

// File: rtl/srt_pkg.sv
package srt_pkg;
  typedef struct packed {
    logic allocEn;
    logic bumpEn;
    logic relIncEn;
    logic relRelEn;
    logic restoreEn;
    logic saveEn;
    logic pendRelEn;
  } srtStrobe_t;
endpackage

// File: rtl/srt_control.sv
module srt_control
  import srt_pkg::*;
#(
  parameter int NUM_ENTRIES = 32,
  parameter int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic                   refValid,
  input  logic                   relValid,
  input  logic                   ckSave,
  input  logic                   ckRestore,
  input  logic [NUM_ENTRIES-1:0] refHitVec,
  input  logic [NUM_ENTRIES-1:0] relHitVec,
  input  logic [NUM_ENTRIES-1:0] freeVec,
  input  logic [NUM_ENTRIES-1:0] refMaxVec,
  input  logic [NUM_ENTRIES-1:0] eqVec,
  input  logic [NUM_ENTRIES-1:0] pendVec,
  output srtStrobe_t             strb,
  output logic [IDX_W-1:0]       allocIdx,
  output logic [IDX_W-1:0]       refIdx,
  output logic [IDX_W-1:0]       relIdx,
  output logic [IDX_W-1:0]       pendIdx,
  output logic                   refAccept,
  output logic                   relFree,
  output logic                   recFreeValid
);
  logic refHit, relHit, anyFree, relEq, refSat;

  // lowest-index encoders
  always_comb begin
    allocIdx = '0;
    refIdx   = '0;
    relIdx   = '0;
    pendIdx  = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (freeVec[i])   allocIdx = IDX_W'(i);
      if (refHitVec[i]) refIdx   = IDX_W'(i);
      if (relHitVec[i]) relIdx   = IDX_W'(i);
      if (pendVec[i])   pendIdx  = IDX_W'(i);
    end
  end

  assign refHit       = |refHitVec;
  assign relHit       = |relHitVec;
  assign anyFree      = |freeVec;
  assign relEq        = eqVec[relIdx];
  assign refSat       = refMaxVec[refIdx];
  assign recFreeValid = |pendVec;

  always_comb begin
    strb           = '0;
    strb.restoreEn = ckRestore;
    strb.saveEn    = ckSave;
    strb.pendRelEn = recFreeValid;
    if (!ckRestore) begin
      strb.relRelEn = relValid && relHit && relEq;
      strb.relIncEn = relValid && relHit && !relEq;
      strb.allocEn  = refValid && !refHit && anyFree;
      strb.bumpEn   = refValid && refHit && !refSat &&
                      !(strb.relRelEn && (relIdx == refIdx));
    end
  end

  assign refAccept = strb.allocEn || strb.bumpEn;
  assign relFree   = !ckRestore && relValid && (!relHit || relEq);
endmodule

// File: rtl/srt_datapath.sv
module srt_datapath
  import srt_pkg::*;
#(
  parameter int NUM_ENTRIES = 32,
  parameter int CNT_W       = 3,
  parameter int PREG_W      = 8,
  parameter int NUM_CKPT    = 4,
  parameter int IDX_W       = $clog2(NUM_ENTRIES),
  parameter int CKPT_W      = $clog2(NUM_CKPT)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  srtStrobe_t             strb,
  input  logic [IDX_W-1:0]       allocIdx,
  input  logic [IDX_W-1:0]       refIdx,
  input  logic [IDX_W-1:0]       relIdx,
  input  logic [IDX_W-1:0]       pendIdx,
  input  logic [PREG_W-1:0]      refPreg,
  input  logic [PREG_W-1:0]      relPreg,
  input  logic [CKPT_W-1:0]      ckSaveId,
  input  logic [CKPT_W-1:0]      ckRestoreId,
  output logic [NUM_ENTRIES-1:0] refHitVec,
  output logic [NUM_ENTRIES-1:0] relHitVec,
  output logic [NUM_ENTRIES-1:0] freeVec,
  output logic [NUM_ENTRIES-1:0] refMaxVec,
  output logic [NUM_ENTRIES-1:0] eqVec,
  output logic [NUM_ENTRIES-1:0] pendVec,
  output logic [PREG_W-1:0]      recFreePreg
);
  logic [NUM_ENTRIES-1:0] valid, pend, freeNow;
  logic [PREG_W-1:0]      tag    [NUM_ENTRIES];
  logic [CNT_W-1:0]       refCnt [NUM_ENTRIES];
  logic [CNT_W-1:0]       comCnt [NUM_ENTRIES];
  logic [CNT_W-1:0]       ckRef  [NUM_CKPT][NUM_ENTRIES];

  assign freeVec     = ~valid & ~pend;
  assign pendVec     = pend;
  assign recFreePreg = tag[pendIdx];

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
    logic [CNT_W-1:0] rstRef;
    logic             rstDrop, rstQuiet;

    assign refHitVec[e] = valid[e] && (tag[e] == refPreg);
    assign relHitVec[e] = valid[e] && (tag[e] == relPreg);
    assign eqVec[e]     = ~|(refCnt[e] ^ comCnt[e]);
    assign refMaxVec[e] = &refCnt[e];
    assign rstRef       = ckRef[ckRestoreId][e];
    assign rstDrop      = strb.restoreEn && valid[e] && (comCnt[e] > rstRef);
    assign rstQuiet     = strb.restoreEn && valid[e] && (rstRef == '0) && (comCnt[e] == '0);
    assign freeNow[e]   = rstDrop || rstQuiet ||
                          (strb.relRelEn && (relIdx == IDX_W'(e)));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid[e]  <= 1'b0;
        pend[e]   <= 1'b0;
        tag[e]    <= '0;
        refCnt[e] <= '0;
        comCnt[e] <= '0;
      end else begin
        if (strb.pendRelEn && (pendIdx == IDX_W'(e))) pend[e] <= 1'b0;
        if (strb.restoreEn) begin
          if (rstDrop) begin
            valid[e]  <= 1'b0;
            pend[e]   <= 1'b1;
            refCnt[e] <= '0;
            comCnt[e] <= '0;
          end else if (rstQuiet) begin
            valid[e]  <= 1'b0;
            refCnt[e] <= '0;
          end else if (valid[e]) begin
            refCnt[e] <= rstRef;
          end
        end else begin
          if (strb.allocEn && (allocIdx == IDX_W'(e))) begin
            valid[e]  <= 1'b1;
            tag[e]    <= refPreg;
            refCnt[e] <= CNT_W'(1);
            comCnt[e] <= '0;
          end
          if (strb.bumpEn && (refIdx == IDX_W'(e)))
            refCnt[e] <= refCnt[e] + CNT_W'(1);
          if (strb.relIncEn && (relIdx == IDX_W'(e)))
            comCnt[e] <= comCnt[e] + CNT_W'(1);
          if (strb.relRelEn && (relIdx == IDX_W'(e))) begin
            valid[e]  <= 1'b0;
            refCnt[e] <= '0;
            comCnt[e] <= '0;
          end
        end
      end
    end

    for (genvar c = 0; c < NUM_CKPT; c++) begin : g_ckpt
      always_ff @(posedge clk) begin
        if (!rst_n)
          ckRef[c][e] <= '0;
        else if (freeNow[e])
          ckRef[c][e] <= '0;
        else if (strb.saveEn && (ckSaveId == CKPT_W'(c)))
          ckRef[c][e] <= refCnt[e];
      end
    end
  end
endmodule

// File: rtl/shared_reg_tracker.sv
module shared_reg_tracker
  import srt_pkg::*;
#(
  parameter int NUM_ENTRIES = 32,
  parameter int CNT_W       = 3,
  parameter int PREG_W      = 8,
  parameter int NUM_CKPT    = 4,
  localparam int IDX_W      = $clog2(NUM_ENTRIES),
  localparam int CKPT_W     = $clog2(NUM_CKPT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              refValid,
  input  logic [PREG_W-1:0] refPreg,
  output logic              refAccept,
  input  logic              relValid,
  input  logic [PREG_W-1:0] relPreg,
  output logic              relFree,
  input  logic              ckSave,
  input  logic [CKPT_W-1:0] ckSaveId,
  input  logic              ckRestore,
  input  logic [CKPT_W-1:0] ckRestoreId,
  output logic              recFreeValid,
  output logic [PREG_W-1:0] recFreePreg
);
  srtStrobe_t             strb;
  logic [IDX_W-1:0]       allocIdx, refIdx, relIdx, pendIdx;
  logic [NUM_ENTRIES-1:0] refHitVec, relHitVec, freeVec, refMaxVec, eqVec, pendVec;

  srt_control #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_ctrl (
    .refValid(refValid), .relValid(relValid), .ckSave(ckSave), .ckRestore(ckRestore),
    .refHitVec(refHitVec), .relHitVec(relHitVec), .freeVec(freeVec),
    .refMaxVec(refMaxVec), .eqVec(eqVec), .pendVec(pendVec),
    .strb(strb), .allocIdx(allocIdx), .refIdx(refIdx), .relIdx(relIdx),
    .pendIdx(pendIdx), .refAccept(refAccept), .relFree(relFree),
    .recFreeValid(recFreeValid)
  );

  srt_datapath #(
    .NUM_ENTRIES(NUM_ENTRIES), .CNT_W(CNT_W), .PREG_W(PREG_W),
    .NUM_CKPT(NUM_CKPT), .IDX_W(IDX_W), .CKPT_W(CKPT_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .allocIdx(allocIdx), .refIdx(refIdx), .relIdx(relIdx), .pendIdx(pendIdx),
    .refPreg(refPreg), .relPreg(relPreg),
    .ckSaveId(ckSaveId), .ckRestoreId(ckRestoreId),
    .refHitVec(refHitVec), .relHitVec(relHitVec), .freeVec(freeVec),
    .refMaxVec(refMaxVec), .eqVec(eqVec), .pendVec(pendVec),
    .recFreePreg(recFreePreg)
  );
endmodule

// File: rtl/srt_checker.sv
module srt_checker (
  input logic clk,
  input logic rst_n,
  input logic refValid,
  input logic refAccept,
  input logic relValid,
  input logic relFree,
  input logic ckRestore,
  input logic recFreeValid
);
  p_accept_has_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    refAccept |-> refValid);

  p_free_has_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    relFree |-> relValid);

  p_restore_mutes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ckRestore |-> (!refAccept && !relFree));

  p_release_follows_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(recFreeValid) |-> $past(ckRestore));

  p_reset_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !recFreeValid);
endmodule

bind shared_reg_tracker srt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .refValid(refValid), .refAccept(refAccept),
  .relValid(relValid), .relFree(relFree), .ckRestore(ckRestore),
  .recFreeValid(recFreeValid)
);

// File: tb/shared_reg_tracker_bench.sv
module shared_reg_tracker_bench;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       refValid = 1'b0, relValid = 1'b0, ckSave = 1'b0, ckRestore = 1'b0;
  logic [7:0] refPreg = '0, relPreg = '0;
  logic [1:0] ckSaveId = '0, ckRestoreId = '0;
  logic       refAccept, relFree, recFreeValid;
  logic [7:0] recFreePreg;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [3:0] mask;   // 0 refAccept, 1 relFree, 2 recFreeValid, 3 recFreePreg
    logic       eAcc;
    logic       eFree;
    logic       eRec;
    logic [7:0] ePreg;
    string      req;
  } expItem_t;

  expItem_t expQ[$];

  shared_reg_tracker u_shared_reg_tracker (
    .clk(clk), .rst_n(rst_n), .refValid(refValid), .refPreg(refPreg),
    .refAccept(refAccept), .relValid(relValid), .relPreg(relPreg),
    .relFree(relFree), .ckSave(ckSave), .ckSaveId(ckSaveId),
    .ckRestore(ckRestore), .ckRestoreId(ckRestoreId),
    .recFreeValid(recFreeValid), .recFreePreg(recFreePreg)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic fail(input string req, input string what, input int act, input int exp);
    errors++;
    $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
  endtask

  // monitor: pops one expectation per cycle, a quarter period after the drive edge
  initial forever begin
    @(negedge clk);
    #(PERIOD/4);
    if (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      if (it.mask[0]) begin checks++; if (refAccept !== it.eAcc) fail(it.req, "refAccept", int'(refAccept), int'(it.eAcc)); end
      if (it.mask[1]) begin checks++; if (relFree !== it.eFree) fail(it.req, "relFree", int'(relFree), int'(it.eFree)); end
      if (it.mask[2]) begin checks++; if (recFreeValid !== it.eRec) fail(it.req, "recFreeValid", int'(recFreeValid), int'(it.eRec)); end
      if (it.mask[3]) begin checks++; if (recFreePreg !== it.ePreg) fail(it.req, "recFreePreg", int'(recFreePreg), int'(it.ePreg)); end
    end
  end

  task automatic step(input logic rv, input logic [7:0] rp, input logic lv, input logic [7:0] lp,
                      input logic sv, input logic [1:0] sid, input logic xv, input logic [1:0] xid,
                      input logic [3:0] m, input logic eA, input logic eF, input logic eR,
                      input logic [7:0] eP, input string req);
    expItem_t it;
    @(negedge clk);
    refValid = rv; refPreg = rp; relValid = lv; relPreg = lp;
    ckSave = sv; ckSaveId = sid; ckRestore = xv; ckRestoreId = xid;
    it.mask = m; it.eAcc = eA; it.eFree = eF; it.eRec = eR; it.ePreg = eP; it.req = req;
    expQ.push_back(it);
  endtask

  task automatic doRef(input logic [7:0] p, input logic eA, input string req);
    step(1, p, 0, 0, 0, 0, 0, 0, 4'b0001, eA, 0, 0, 0, req);
  endtask

  task automatic doRel(input logic [7:0] p, input logic eF, input string req);
    step(0, 0, 1, p, 0, 0, 0, 0, 4'b0010, 0, eF, 0, 0, req);
  endtask

  task automatic doSave(input logic [1:0] id);
    step(0, 0, 0, 0, 1, id, 0, 0, 4'b0000, 0, 0, 0, 0, "");
  endtask

  task automatic idleRec(input logic eR, input logic [7:0] eP, input string req);
    step(0, 0, 0, 0, 0, 0, 0, 0, eR ? 4'b1100 : 4'b0100, 0, 0, eR, eP, req);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    refValid = 0; relValid = 0; ckSave = 0; ckRestore = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    idleRec(0, 0, "R12");
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R12: reset leaves nothing tracked
    doReset();
    doRel(8'd5, 1, "R12 untracked after reset");

    // R1, R3, R4, R5, R6
    doRef(8'd10, 1, "R1 allocate");
    doRef(8'd10, 1, "R3 bump");
    doRel(8'd10, 0, "R4 ref2 com0");
    doRel(8'd10, 0, "R4 ref2 com1");
    doRel(8'd10, 1, "R5 equal frees");
    doRel(8'd10, 1, "R6 miss frees");

    // R3 saturation at 7
    doReset();
    for (int i = 0; i < 7; i++) doRef(8'd20, 1, "R3 count up");
    doRef(8'd20, 0, "R3 saturated refused");
    for (int i = 0; i < 7; i++) doRel(8'd20, 0, "R4 com climbs");
    doRel(8'd20, 1, "R5 saturated entry frees");

    // R2 full table
    doReset();
    for (int i = 0; i < 32; i++) doRef(8'(100 + i), 1, "R1 fill");
    doRef(8'd200, 0, "R2 full refused");
    doRef(8'd100, 1, "R3 tracked while full");
    doRel(8'd101, 0, "R4 hit unequal");
    doRel(8'd101, 1, "R5 release one");
    doRef(8'd200, 1, "R1 reuse freed slot");
    doRel(8'd200, 0, "R1 new entry ref1 com0");

    // R7, R8: restore with com above restored ref, and zero/zero entry
    doReset();
    doRef(8'd30, 1, "R1 alloc 30");
    doSave(2'd1);
    doRef(8'd30, 1, "R3 bump 30");
    doRef(8'd31, 1, "R1 alloc 31");
    doRel(8'd30, 0, "R4 com1");
    doRel(8'd30, 0, "R4 com2");
    step(0, 0, 0, 0, 0, 0, 1, 2'd1, 4'b0100, 0, 0, 0, 0, "R7 restore cycle");
    idleRec(1, 8'd30, "R7 recovery release");
    idleRec(0, 0, "R8 nothing more released");
    doRel(8'd31, 1, "R8 entry dropped");
    doRel(8'd30, 1, "R7 entry dropped");

    // R7: restored ref kept
    doReset();
    doRef(8'd40, 1, "R1 alloc 40");
    doSave(2'd2);
    doRef(8'd40, 1, "R3 bump 40");
    step(0, 0, 0, 0, 0, 0, 1, 2'd2, 4'b0000, 0, 0, 0, 0, "");
    idleRec(0, 0, "R7 no release when kept");
    doRel(8'd40, 0, "R7 restored ref1");
    doRel(8'd40, 1, "R7 restored ref1 frees on second");

    // R9: checkpoint cleared when entry freed
    doReset();
    doRef(8'd50, 1, "R1 alloc 50");
    doSave(2'd0);
    doRel(8'd50, 0, "R4 50");
    doRel(8'd50, 1, "R5 50");
    doRef(8'd51, 1, "R1 reuse slot 51");
    step(0, 0, 0, 0, 0, 0, 1, 2'd0, 4'b0000, 0, 0, 0, 0, "");
    idleRec(0, 0, "R9 no release");
    doRel(8'd51, 1, "R9 stale checkpoint cleared");

    // R10: ports ignored during restore
    doReset();
    step(1, 8'd70, 1, 8'd71, 0, 0, 1, 2'd3, 4'b0011, 0, 0, 0, 0, "R10 muted");
    doRel(8'd70, 1, "R10 reference ignored");

    // R11: same-cycle interactions
    doReset();
    step(1, 8'd60, 1, 8'd60, 0, 0, 0, 0, 4'b0011, 1, 1, 0, 0, "R11 pre-alloc view");
    doRel(8'd60, 0, "R11 entry now live");
    doRef(8'd80, 1, "R1 alloc 80");
    doRel(8'd80, 0, "R4 80");
    step(1, 8'd80, 1, 8'd80, 0, 0, 0, 0, 4'b0011, 0, 1, 0, 0, "R11 ref to freeing entry refused");
    doRel(8'd80, 1, "R11 entry gone");

    @(negedge clk);
    refValid = 0; relValid = 0; ckSave = 0; ckRestore = 0;
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule